// File: doc/BRIEF.md
# Low-Power Halt Release Controller

This block decides when a halted CPU core wakes up and what it does on waking. The core starts a halt by pulsing `halt_go` with the chosen power mode. The block then runs a fixed-length entry window before it reports the core as fully halted. While halted it watches a vector of maskable interrupt requests, each with a 3-bit priority level, a non-maskable request, and a 3-bit mask level. From these it produces a one-cycle wake strobe, a service flag and the identity of the interrupt to take.

The lowest-numbered request lines form an external group. A line in this group can wake the core even when its level is below the mask. In that case the interrupt is not serviced, and its request flag stays set at the source. In the two deeper modes, an external request that arrives during the entry window cannot wake the core. Instead it is held internally. When a later request wakes the core, the held request is arbitrated against the new one, and the loser is serviced on the next cycle.

A synchronous reset always ends the halt. If the core was in the deepest mode, release is delayed by a parameterized oscillator settle count. A one-cycle reinit pulse tells the rest of the chip that settings return to defaults while RAM is kept. An interrupt-driven release never produces this pulse.

Top module: `halt_release_ctrl`

## Requirements
- R1: While halted, a request whose level is greater than or equal to `mask_lvl` causes `wake` and `service` to be high together in the cycle after the clock edge that sees it, with `irq_id` equal to the line index.
- R2: While halted, a request on a line at index `EXT_CNT` or above whose level is below `mask_lvl` does not wake the core, and `halted` stays high.
- R3: While halted, with no qualifying request and no NMI, a request on a line below index `EXT_CNT` whose level is below the mask gives `wake` high with `service` low, and `irq_id` equal to the lowest such line.
- R4: While halted, `nmi` always gives `wake` and `service` with `irq_id` equal to `N_IRQ`, whatever the mask is and ahead of any maskable request.
- R5: Among qualifying requests, the one with the highest level wins. On equal levels the lower index wins.
- R6: `wake` is a single-cycle pulse. `service` is high only together with `wake` or in the cycle right after a wake. `reinit` never rises because of an interrupt wake.
- R7: `halted` rises exactly `ENTRY_CYC` cycles after the cycle in which `halt_go` is accepted. In modes `halt_mode`=1 and `halt_mode`=2 (and 3, which acts like 2), no wake occurs during that window. An external-group request seen in the window is held, and a held request by itself never wakes the core.
- R8: In mode `halt_mode`=0, requests are evaluated during the entry window exactly as when halted.
- R9: When a wake occurs with a held request whose level is at least the mask, the higher-ranked of the waking request and the held request is serviced with the wake. The other is serviced (`service` high, `wake` low) in the next cycle. A held request below the mask is dropped.
- R10: After reset is released from a halt in mode 2 or 3, `settle_wait` is high for exactly `SETTLE_CYC` cycles, and then `reinit` pulses once. After any other reset, `reinit` pulses in the first cycle after release and `settle_wait` stays low.
- R11: During and after reset, `halted`, `wake` and `service` are low. While running (not halting), requests and NMI produce no wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also ends any halt |
| halt_go | input | 1 | Pulse from the core starting a halt (accepted only while running) |
| halt_mode | input | 2 | 0 = light idle, 1 = deep idle, 2 = stop, 3 = treated as stop |
| mask_lvl | input | 3 | Interrupt mask level |
| irq_req | input | N_IRQ | Maskable request lines; indices below EXT_CNT are the external group |
| irq_lvl | input | 3*N_IRQ | Priority level of each line, line i at bits [3i+2:3i] |
| nmi | input | 1 | Non-maskable interrupt request |
| wake | output | 1 | One-cycle wake strobe |
| service | output | 1 | Service the interrupt named by irq_id this cycle |
| irq_id | output | $clog2(N_IRQ+1) | Chosen interrupt; N_IRQ stands for NMI |
| settle_wait | output | 1 | Oscillator settle count running after reset from stop |
| halted | output | 1 | Core fully halted (entry window complete) |
| reinit | output | 1 | One-cycle pulse: reset release complete, settings reinitialized |

## Verification
The hardest situation to reach from the ports is a request captured during the entry window of a deep mode, followed by a later wake that must be ranked against it. The bench pulses an external line for one cycle just after `halt_go` is accepted. It checks that `wake` stays low until `halted` rises and for a few cycles after. It then raises a second request chosen above, below and equal to the held level, or an NMI, and checks both the wake cycle and the follow-up service cycle. The single-request and pairwise-level sweeps over all modes and masks cover the rest of the wake and ranking rules.

// File: rtl/hrc_pkg.sv
package hrc_pkg;

  localparam int LVL_W = 3;

  typedef enum logic [1:0] {
    MODE_IDLE_LIGHT = 2'd0,
    MODE_IDLE_DEEP  = 2'd1,
    MODE_STOP       = 2'd2,
    MODE_STOP_ALT   = 2'd3
  } pwr_mode_t;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_ENTER  = 3'd1,
    ST_HALTED = 3'd2,
    ST_RST    = 3'd3,
    ST_SETTLE = 3'd4,
    ST_SECOND = 3'd5
  } hrc_state_t;

  // level clears the mask when it is not below it
  function automatic logic lvl_at_least(input logic [LVL_W-1:0] lvl,
                                        input logic [LVL_W-1:0] mask);
    return lvl >= mask;
  endfunction

  // a outranks b: higher level, or equal level and lower index
  function automatic logic outranks(input logic [LVL_W-1:0] lvl_a, input int idx_a,
                                    input logic [LVL_W-1:0] lvl_b, input int idx_b);
    return (lvl_a > lvl_b) || ((lvl_a == lvl_b) && (idx_a < idx_b));
  endfunction

  // modes that stop the oscillator need a settle delay after reset
  function automatic logic mode_stops_osc(input pwr_mode_t m);
    return m[1];
  endfunction

endpackage

// File: rtl/hrc_wake_eval.sv
module hrc_wake_eval
  import hrc_pkg::*;
#(
  parameter int N_IRQ   = 8,
  parameter int EXT_CNT = 5
) (
  input  logic [N_IRQ-1:0]       req,
  input  logic [N_IRQ*LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]       mask,
  output logic [N_IRQ-1:0]       lvl_ok,
  output logic [N_IRQ-1:0]       qual,
  output logic [N_IRQ-1:0]       ext_low
);

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    assign lvl_ok[g] = lvl_at_least(lvl[g*LVL_W +: LVL_W], mask);
    assign qual[g]   = req[g] & lvl_ok[g];
    if (g < EXT_CNT) begin : g_ext
      assign ext_low[g] = req[g] & ~lvl_ok[g];
    end else begin : g_int
      assign ext_low[g] = 1'b0;
    end
  end

endmodule

// File: rtl/hrc_arbiter.sv
module hrc_arbiter
  import hrc_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int IW    = 3
) (
  input  logic [N_IRQ-1:0]       valid,
  input  logic [N_IRQ*LVL_W-1:0] lvl,
  output logic                   found,
  output logic [IW-1:0]          idx,
  output logic [LVL_W-1:0]       best_lvl
);

  always_comb begin
    found    = 1'b0;
    idx      = '0;
    best_lvl = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (valid[i] && (!found || (lvl[i*LVL_W +: LVL_W] > best_lvl))) begin
        found    = 1'b1;
        idx      = IW'(i);
        best_lvl = lvl[i*LVL_W +: LVL_W];
      end
    end
  end

  // R5
  always_comb begin
    pick_valid_chk: assert (!found || valid[idx]);
  end

endmodule

// File: rtl/hrc_settle.sv
module hrc_settle #(
  parameter int CYC = 300000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  // R10
  settle_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

endmodule

// File: rtl/halt_release_ctrl.sv
module halt_release_ctrl
  import hrc_pkg::*;
#(
  parameter int N_IRQ      = 8,
  parameter int EXT_CNT    = 5,
  parameter int ENTRY_CYC  = 5,
  parameter int SETTLE_CYC = 300000
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            halt_go,
  input  logic [1:0]                      halt_mode,
  input  logic [2:0]                      mask_lvl,
  input  logic [N_IRQ-1:0]                irq_req,
  input  logic [N_IRQ*3-1:0]              irq_lvl,
  input  logic                            nmi,
  output logic                            wake,
  output logic                            service,
  output logic [$clog2(N_IRQ+1)-1:0]      irq_id,
  output logic                            settle_wait,
  output logic                            halted,
  output logic                            reinit
);

  localparam int IDW = $clog2(N_IRQ + 1);
  localparam int IW  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam int EW  = $clog2(ENTRY_CYC + 1);
  localparam logic [IDW-1:0] NMI_ID = IDW'(N_IRQ);

  hrc_state_t       st;
  pwr_mode_t        mode_q;
  logic [EW-1:0]    ent_cnt;
  logic [N_IRQ-1:0] held_q;
  logic             from_stop_q;
  logic             wake_q, svc_q, reinit_q;
  logic [IDW-1:0]   id_q, sec_id_q;

  // named internal events
  logic             eval_on, wake_cond, in_reset_path, deep_window;
  logic [N_IRQ-1:0] ext_sel, lvl_ok, live_qual, live_low, held_qual;
  logic             lf, hf, low_found;
  logic [IW-1:0]    li, hi;
  logic [LVL_W-1:0] ll, hl;
  logic [IDW-1:0]   low_idx, first_id, sec_id;
  logic             first_svc, sec_valid;
  logic             settle_start, settle_busy, settle_done;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_extsel
    assign ext_sel[g] = (g < EXT_CNT);
  end

  hrc_wake_eval #(.N_IRQ(N_IRQ), .EXT_CNT(EXT_CNT)) u_eval (
    .req    (irq_req),
    .lvl    (irq_lvl),
    .mask   (mask_lvl),
    .lvl_ok (lvl_ok),
    .qual   (live_qual),
    .ext_low(live_low)
  );

  assign held_qual = held_q & lvl_ok;

  hrc_arbiter #(.N_IRQ(N_IRQ), .IW(IW)) u_arb_live (
    .valid(live_qual), .lvl(irq_lvl), .found(lf), .idx(li), .best_lvl(ll)
  );

  hrc_arbiter #(.N_IRQ(N_IRQ), .IW(IW)) u_arb_held (
    .valid(held_qual), .lvl(irq_lvl), .found(hf), .idx(hi), .best_lvl(hl)
  );

  // lowest external line below the mask
  always_comb begin
    low_found = 1'b0;
    low_idx   = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (live_low[i]) begin
        low_found = 1'b1;
        low_idx   = IDW'(i);
      end
    end
  end

  assign deep_window = (st == ST_ENTER) && (mode_q != MODE_IDLE_LIGHT);
  assign eval_on     = (st == ST_HALTED) || ((st == ST_ENTER) && (mode_q == MODE_IDLE_LIGHT));
  assign wake_cond   = eval_on && (nmi || lf || low_found);

  // choose what is serviced with the wake and what follows it
  always_comb begin
    first_id  = '0;
    first_svc = 1'b0;
    sec_valid = 1'b0;
    sec_id    = IDW'(hi);
    if (nmi) begin
      first_id  = NMI_ID;
      first_svc = 1'b1;
      sec_valid = hf;
    end else if (lf) begin
      first_svc = 1'b1;
      if (hf && outranks(hl, int'(hi), ll, int'(li))) begin
        first_id  = IDW'(hi);
        sec_valid = 1'b1;
        sec_id    = IDW'(li);
      end else begin
        first_id  = IDW'(li);
        sec_valid = hf && (hi != li);
      end
    end else begin
      first_id  = low_idx;
      sec_valid = hf;
    end
  end

  assign settle_start = (st == ST_RST) && !rst && from_stop_q;

  hrc_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst  (rst),
    .start(settle_start),
    .busy (settle_busy),
    .done (settle_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      if (st != ST_RST)
        from_stop_q <= ((st == ST_HALTED) || (st == ST_ENTER)) && mode_stops_osc(mode_q);
      st       <= ST_RST;
      wake_q   <= 1'b0;
      svc_q    <= 1'b0;
      reinit_q <= 1'b0;
      id_q     <= '0;
      sec_id_q <= '0;
      held_q   <= '0;
      ent_cnt  <= '0;
      mode_q   <= MODE_IDLE_LIGHT;
    end else begin
      wake_q   <= 1'b0;
      svc_q    <= 1'b0;
      reinit_q <= 1'b0;
      unique case (st)
        ST_RST: begin
          if (from_stop_q) st <= ST_SETTLE;
          else begin
            st       <= ST_RUN;
            reinit_q <= 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settle_done) begin
            st       <= ST_RUN;
            reinit_q <= 1'b1;
          end
        end
        ST_RUN: begin
          if (halt_go) begin
            st      <= ST_ENTER;
            mode_q  <= pwr_mode_t'(halt_mode);
            ent_cnt <= EW'(ENTRY_CYC - 1);
            held_q  <= '0;
          end
        end
        ST_ENTER, ST_HALTED: begin
          if (wake_cond) begin
            wake_q   <= 1'b1;
            svc_q    <= first_svc;
            id_q     <= first_id;
            sec_id_q <= sec_id;
            held_q   <= '0;
            st       <= sec_valid ? ST_SECOND : ST_RUN;
          end else if (st == ST_ENTER) begin
            if (mode_q != MODE_IDLE_LIGHT) held_q <= held_q | (irq_req & ext_sel);
            if (ent_cnt == '0) st <= ST_HALTED;
            else               ent_cnt <= ent_cnt - 1'b1;
          end
        end
        ST_SECOND: begin
          svc_q <= 1'b1;
          id_q  <= sec_id_q;
          st    <= ST_RUN;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign wake          = wake_q;
  assign service       = svc_q;
  assign irq_id        = id_q;
  assign reinit        = reinit_q;
  assign halted        = (st == ST_HALTED);
  assign settle_wait   = settle_busy;
  assign in_reset_path = (st == ST_RST) || (st == ST_SETTLE);

  // R6
  wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);

  // R6
  service_tied_chk: assert property (@(posedge clk) disable iff (rst)
    (service && !wake) |-> $past(wake));

  // R6
  reinit_src_chk: assert property (@(posedge clk) disable iff (rst)
    reinit |-> $past(in_reset_path));

  // R4
  nmi_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && nmi) |=> (wake && service && (irq_id == NMI_ID)));

  // R3
  nosvc_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (wake && !service) |-> (irq_id < IDW'(EXT_CNT)));

  // R7
  window_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    deep_window |=> !wake);

  // R10
  settle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    settle_wait |-> (!wake && !service && !halted));

endmodule

// File: tb/test_halt_release_ctrl.sv
module test_halt_release_ctrl;

  localparam int N   = 8;
  localparam int EXT = 5;
  localparam int ENT = 5;
  localparam int SET = 20;
  localparam int IDW = 4;
  localparam int NMI = N;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1, halt_go = 1'b0, nmi = 1'b0;
  logic [1:0]     halt_mode = '0;
  logic [2:0]     mask_lvl = '0;
  logic [N-1:0]   irq_req = '0;
  logic [N*3-1:0] irq_lvl = '0;
  logic           wake, service, settle_wait, halted, reinit;
  logic [IDW-1:0] irq_id;

  int errs = 0, checks = 0;

  halt_release_ctrl #(.N_IRQ(N), .EXT_CNT(EXT), .ENTRY_CYC(ENT), .SETTLE_CYC(SET)) i_halt_release_ctrl (
    .clk(clk), .rst(rst), .halt_go(halt_go), .halt_mode(halt_mode), .mask_lvl(mask_lvl),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .nmi(nmi), .wake(wake), .service(service),
    .irq_id(irq_id), .settle_wait(settle_wait), .halted(halted), .reinit(reinit)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clr();
    irq_req = '0; irq_lvl = '0; nmi = 1'b0; halt_go = 1'b0;
  endtask

  task automatic set_line(int i, int l);
    irq_req[i] = 1'b1;
    irq_lvl[i*3 +: 3] = 3'(l);
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); step();
    chk("R11 halted in reset", int'(halted), 0);
    rst = 1'b0; step();
  endtask

  // start a halt; returns cycles until halted
  task automatic enter(int mode, int m, output int win);
    halt_mode = 2'(mode); mask_lvl = 3'(m); halt_go = 1'b1;
    step();
    halt_go = 1'b0;
    win = 0;
    while (!halted && win < 50) begin win++; step(); end
  endtask

  // held request in the window, then a new request (new_i < 0 means NMI)
  task automatic held_case(string tag, int mode, int hi_, int hl_, int new_i, int new_l,
                           int e1s, int e1, int e2s, int e2);
    int win;
    clr(); mask_lvl = 3'd3; halt_mode = 2'(mode); halt_go = 1'b1;
    step();
    halt_go = 1'b0; set_line(hi_, hl_);
    step();
    irq_req = '0;
    win = 1;
    while (!halted && win < 50) begin
      chk({tag, " R7 no wake in window"}, int'(wake), 0);
      win++; step();
    end
    chk({tag, " R7 window length"}, win, ENT);
    for (int k = 0; k < 3; k++) begin
      step();
      chk({tag, " R7 held alone no wake"}, int'(wake), 0);
    end
    if (new_i < 0) nmi = 1'b1; else set_line(new_i, new_l);
    step();
    chk({tag, " R9 wake"}, int'(wake), 1);
    chk({tag, " R9 first service"}, int'(service), e1s);
    chk({tag, " R9 first id"}, int'(irq_id), e1);
    irq_req = '0; nmi = 1'b0;
    step();
    chk({tag, " R9 second wake low"}, int'(wake), 0);
    chk({tag, " R9 second service"}, int'(service), e2s);
    if (e2s == 1) chk({tag, " R9 second id"}, int'(irq_id), e2);
    step();
    chk({tag, " R9 service ends"}, int'(service), 0);
    clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int win, cnt;
    int ew, es, eid;
    step(); step();
    rst = 1'b0; step();
    // R11 and R10: reset state and plain reset release
    chk("R10 reinit after plain reset", int'(reinit), 1);
    chk("R10 no settle after plain reset", int'(settle_wait), 0);
    chk("R11 wake after reset", int'(wake), 0);
    chk("R11 service after reset", int'(service), 0);
    chk("R11 halted after reset", int'(halted), 0);
    step();
    chk("R10 reinit single pulse", int'(reinit), 0);

    // R11: requests while running are ignored
    set_line(5, 7); set_line(0, 7); nmi = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R11 run wake", int'(wake), 0);
      chk("R11 run service", int'(service), 0);
    end
    clr(); step();

    // R1 R2 R3 R4 R6 R7: single-request sweep over modes, masks, lines, levels
    for (int mode = 0; mode < 3; mode++)
      for (int m = 0; m < 8; m++)
        for (int i = 0; i < N; i++)
          for (int l = 0; l < 8; l++) begin
            clr();
            enter(mode, m, win);
            if (win != ENT) chk("R7 entry length", win, ENT);
            set_line(i, l);
            step();
            if (l >= m)        begin ew = 1; es = 1; eid = i; end
            else if (i < EXT)  begin ew = 1; es = 0; eid = i; end
            else               begin ew = 0; es = 0; eid = 0; end
            if (ew == 1) begin
              chk(l >= m ? "R1 wake" : "R3 wake", int'(wake), 1);
              chk(l >= m ? "R1 service" : "R3 no service", int'(service), es);
              chk(l >= m ? "R1 id" : "R3 id", int'(irq_id), eid);
              clr(); step();
              chk("R6 wake pulse", int'(wake), 0);
              chk("R6 service pulse", int'(service), 0);
              chk("R6 no reinit", int'(reinit), 0);
            end else begin
              chk("R2 no wake", int'(wake), 0);
              step();
              chk("R2 still halted", int'(halted), 1);
              nmi = 1'b1; step();
              chk("R4 nmi wake", int'(wake), 1);
              chk("R4 nmi service", int'(service), 1);
              chk("R4 nmi id", int'(irq_id), NMI);
              clr(); step();
            end
          end

    // R5: pairwise level sweep at mask 0
    for (int p = 0; p < 4; p++)
      for (int la = 0; la < 8; la++)
        for (int lb = 0; lb < 8; lb++) begin
          int a, b;
          a = (p == 0) ? 0 : (p == 1) ? 5 : (p == 2) ? 1 : 3;
          b = (p == 0) ? 5 : (p == 1) ? 6 : (p == 2) ? 7 : 4;
          clr();
          enter(1, 0, win);
          set_line(a, la); set_line(b, lb);
          step();
          eid = (la > lb) ? a : (lb > la) ? b : ((a < b) ? a : b);
          chk("R5 arbitration id", int'(irq_id), eid);
          clr(); step();
        end

    // R4: NMI beats a top-level maskable request
    clr(); enter(2, 0, win);
    set_line(5, 7); nmi = 1'b1; step();
    chk("R4 nmi over maskable", int'(irq_id), NMI);
    clr(); step();

    // R8: light idle evaluates during the entry window
    clr(); mask_lvl = 3'd3; halt_mode = 2'd0; halt_go = 1'b1; step();
    halt_go = 1'b0; set_line(2, 6); step();
    chk("R8 window wake", int'(wake), 1);
    chk("R8 window service", int'(service), 1);
    chk("R8 window id", int'(irq_id), 2);
    clr(); step();
    chk("R8 not halted after wake", int'(halted), 0);

    // R7 R9: held requests
    held_case("a", 1, 2, 6, 6, 4, 1, 2, 1, 6);
    held_case("b", 1, 2, 6, 6, 7, 1, 6, 1, 2);
    held_case("c", 2, 2, 6, 6, 6, 1, 2, 1, 6);
    held_case("d", 1, 2, 6, 3, 1, 0, 3, 1, 2);
    held_case("e", 1, 1, 0, 5, 5, 1, 5, 0, 0);
    held_case("f", 2, 4, 5, -1, 0, 1, NMI, 1, 4);

    // R10: reset out of stop waits for settle
    clr(); enter(2, 0, win);
    rst = 1'b1; step(); step();
    chk("R11 halted cleared by reset", int'(halted), 0);
    rst = 1'b0; step();
    cnt = 0;
    while (settle_wait && cnt < 100) begin
      chk("R10 no reinit while settling", int'(reinit), 0);
      cnt++; step();
    end
    chk("R10 settle length", cnt, SET);
    chk("R10 reinit after settle", int'(reinit), 1);
    step();
    chk("R10 reinit pulse ends", int'(reinit), 0);

    // R10: reset out of deep idle has no settle
    clr(); enter(1, 0, win);
    do_reset();
    chk("R10 deep idle no settle", int'(settle_wait), 0);
    chk("R10 deep idle reinit", int'(reinit), 1);
    step();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule